// File: doc/BRIEF.md
# GPIO Edge Detect Interrupt Unit

This block watches a bank of general-purpose input pins (85 by default) for level changes and keeps a sticky record of each qualifying edge. Every pin has its own rising-edge enable and falling-edge enable. Each pin is resynchronised to the block clock. An edge is found by comparing the synchronised level with its value one clock earlier. An edge whose direction is enabled sets that pin's status bit.

Software reaches the block through a simple word-wide register port. It programs the two enable banks, reads the status and clears it by writing ones. The status turns into three level interrupt requests. Pin 0 and pin 1 each have a dedicated request. Every pin from 2 upward feeds one shared request.

The register port uses byte addresses, and every register is 32 bits wide. The rising enables sit at 0x30, 0x34 and 0x38. The falling enables sit at 0x3C, 0x40 and 0x44. The status words sit at 0x48, 0x4C and 0x50. In each bank, pin i maps to word i/32, bit i%32.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin change driven between clock edges is synchronised by two flops and compared with a third. A matching edge becomes visible in its status bit right after the third rising clock edge, and not after the second.
- R2: A 0-to-1 transition sets the status bit only when the pin's rising enable is 1. A 1-to-0 transition sets it only when the falling enable is 1. With both enables set, either direction sets it, and with neither set, no transition does.
- R3: A set status bit stays set when the pin goes back to its former level. It stays set until software clears it.
- R4: Writing a word to a status address clears each bit where the written data holds a 1. Bits where the data holds 0 keep their value, and status bits in other words are untouched.
- R5: While rst_n is low, all enable bits and all status bits are 0, and the three interrupt outputs are low.
- R6: irq_pin0 is high exactly while the status bit of pin 0 is set, and irq_pin1 is high exactly while the status bit of pin 1 is set. Both follow the status in the same cycle.
- R7: irq_shared is high whenever any status bit of pins 2 through 84 is set. It drops once all of those bits are cleared.
- R8: If an enabled edge and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R9: The enable registers are read/write. Bits above the last pin (bits 21..31 of the third word) read as 0 and ignore writes, and so do the same bits of the third status word.
- R10: The register map is rising enables at 0x30/0x34/0x38, falling enables at 0x3C/0x40/0x44, and status at 0x48/0x4C/0x50. Any other address, including ones that are not word aligned, reads as 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 85 | Asynchronous general-purpose input levels |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr |
| irq_pin0 | output | 1 | Dedicated request for pin 0 |
| irq_pin1 | output | 1 | Dedicated request for pin 1 |
| irq_shared | output | 1 | Shared request for pins 2 to 84 |

## Verification
The bound checker watches the status vector against the edge-event vector and the bus on every cycle. It checks four things:
- no status bit appears without a preceding event;
- every event lands even under a simultaneous clear;
- written zeros never drop a bit, and written ones do drop bits with no event;
- the interrupt lines only rise after an event on their own pins.

It also checks the reset state and the zero padding of the last word. The exact three-clock latency, the direction qualification for every pin under all four enable combinations, stickiness after the pin returns, and the address decode can only be shown by the bench's sweeps and scenarios.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_RISE,
        RK_FALL,
        RK_STAT
    } reg_kind_e;

    localparam int RISE_OFS = 'h30;
    localparam int FALL_OFS = 'h3C;
    localparam int STAT_OFS = 'h48;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 85
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int WIDTH = 85
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] rise_en_i,
    input  logic [WIDTH-1:0] fall_en_i,
    output logic [WIDTH-1:0] evt_o
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    always_comb begin
        evt_o = (level_i & ~prev_q & rise_en_i) |
                (~level_i & prev_q & fall_en_i);
    end

endmodule

// File: rtl/gpio_status_w1c.sv
module gpio_status_w1c #(
    parameter int WIDTH = 85
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] status_o
);

    logic [WIDTH-1:0] stat_q;

    // a new event overrides a clear aimed at the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    assign status_o = stat_q;

endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_edge_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 3,
    parameter int IDX_W     = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int SPAN = 4 * NUM_WORDS;

    int a;

    always_comb begin
        a      = int'(addr_i);
        kind_o = RK_NONE;
        idx_o  = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (a >= RISE_OFS && a < RISE_OFS + SPAN) begin
                kind_o = RK_RISE;
                idx_o  = IDX_W'((a - RISE_OFS) / 4);
            end else if (a >= FALL_OFS && a < FALL_OFS + SPAN) begin
                kind_o = RK_FALL;
                idx_o  = IDX_W'((a - FALL_OFS) / 4);
            end else if (a >= STAT_OFS && a < STAT_OFS + SPAN) begin
                kind_o = RK_STAT;
                idx_o  = IDX_W'((a - STAT_OFS) / 4);
            end
        end
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 85,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                irq_pin0,
    output logic                irq_pin1,
    output logic                irq_shared
);

    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    function automatic logic [PAD_W-1:0] valid_bits();
        logic [PAD_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_PINS; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [PAD_W-1:0] VALID = valid_bits();

    reg_kind_e        kind;
    logic [IDX_W-1:0] widx;

    logic [PAD_W-1:0]    rise_pad, fall_pad, clr_pad, stat_pad;
    logic [NUM_PINS-1:0] pin_sync, edge_evt, status_q;

    gpio_reg_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr_i(bus_addr),
        .kind_o(kind),
        .idx_o (widx)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit_rise, hit_fall, hit_stat;
        logic [WORD_W-1:0] keep;

        assign keep     = VALID[w*WORD_W +: WORD_W];
        assign hit_rise = bus_wr && (kind == RK_RISE) && (widx == IDX_W'(w));
        assign hit_fall = bus_wr && (kind == RK_FALL) && (widx == IDX_W'(w));
        assign hit_stat = bus_wr && (kind == RK_STAT) && (widx == IDX_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rise_pad[w*WORD_W +: WORD_W] <= '0;
                fall_pad[w*WORD_W +: WORD_W] <= '0;
            end else begin
                if (hit_rise) rise_pad[w*WORD_W +: WORD_W] <= bus_wdata & keep;
                if (hit_fall) fall_pad[w*WORD_W +: WORD_W] <= bus_wdata & keep;
            end
        end

        assign clr_pad[w*WORD_W +: WORD_W] = hit_stat ? (bus_wdata & keep) : '0;
    end

    gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (pin_sync)
    );

    gpio_edge_detect #(.WIDTH(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (pin_sync),
        .rise_en_i(rise_pad[NUM_PINS-1:0]),
        .fall_en_i(fall_pad[NUM_PINS-1:0]),
        .evt_o    (edge_evt)
    );

    gpio_status_w1c #(.WIDTH(NUM_PINS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (edge_evt),
        .clr_i   (clr_pad[NUM_PINS-1:0]),
        .status_o(status_q)
    );

    always_comb begin
        stat_pad                 = '0;
        stat_pad[NUM_PINS-1:0]   = status_q;
    end

    always_comb begin
        unique case (kind)
            RK_RISE: bus_rdata = rise_pad[int'(widx)*WORD_W +: WORD_W];
            RK_FALL: bus_rdata = fall_pad[int'(widx)*WORD_W +: WORD_W];
            RK_STAT: bus_rdata = stat_pad[int'(widx)*WORD_W +: WORD_W];
            default: bus_rdata = '0;
        endcase
    end

    assign irq_pin0   = status_q[0];
    assign irq_pin1   = status_q[1];
    assign irq_shared = |status_q[NUM_PINS-1:2];

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 85,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic [WORD_W-1:0]   bus_rdata,
    input logic                irq_pin0,
    input logic                irq_pin1,
    input logic                irq_shared,
    input logic [NUM_PINS-1:0] status_q,
    input logic [NUM_PINS-1:0] edge_evt
);

    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int LAST_USED = NUM_PINS - (NUM_WORDS - 1) * WORD_W;

    function automatic logic [WORD_W-1:0] pad_bits();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = LAST_USED; i < WORD_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] PAD_MASK = pad_bits();

    logic [NUM_PINS-1:0] clr_seen;
    logic                last_word_rd;

    always_comb begin
        clr_seen = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_wr && bus_addr == ADDR_W'(STAT_OFS + 4 * (i / WORD_W))
                && bus_wdata[i % WORD_W])
                clr_seen[i] = 1'b1;
        end
    end

    assign last_word_rd = (bus_addr == ADDR_W'(RISE_OFS + 4 * (NUM_WORDS - 1))) ||
                          (bus_addr == ADDR_W'(FALL_OFS + 4 * (NUM_WORDS - 1))) ||
                          (bus_addr == ADDR_W'(STAT_OFS + 4 * (NUM_WORDS - 1)));

    // R2: no status bit appears without an edge event the cycle before
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(edge_evt)) == '0));

    // R3 / R4: bits not written with a one keep their value
    p_keep_uncleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q) & ~$past(clr_seen))
                  == ($past(status_q) & ~$past(clr_seen))));

    // R4: a written one drops the bit when no event arrives with it
    p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr_seen) & ~$past(edge_evt)) == '0));

    // R8: every event lands, even under a simultaneous clear
    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(edge_evt)) == $past(edge_evt)));

    // R6: dedicated requests rise only after their own pin's event
    p_pin0_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pin0) |-> $past(edge_evt[0]));
    p_pin1_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pin1) |-> $past(edge_evt[1]));

    // R7: shared request rises only after an event on pins 2 and up
    p_shared_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_shared) |-> $past(|edge_evt[NUM_PINS-1:2]));

    // R5: reset clears status and requests
    p_reset_state_r5: assert property (@(posedge clk)
        !rst_n |-> (status_q == '0 && !irq_pin0 && !irq_pin1 && !irq_shared));

    // R9: pad bits of the last word always read 0
    p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        last_word_rd |-> ((bus_rdata & PAD_MASK) == '0));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
    .NUM_PINS(NUM_PINS),
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_shared(irq_shared),
    .status_q  (status_q),
    .edge_evt  (edge_evt)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;

    localparam int NP = 85;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_pin0, irq_pin1, irq_shared;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    gpio_edge_irq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pin0  (irq_pin0),
        .irq_pin1  (irq_pin1),
        .irq_shared(irq_shared)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a falling edge
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_irqs(input string req, input logic e0, input logic e1, input logic es);
        check(req, {29'd0, irq_pin0, irq_pin1, irq_shared}, {29'd0, e0, e1, es});
    endtask

    task automatic set_modes(input logic re, input logic fe);
        for (int w = 0; w < 3; w++) begin
            wr(8'(8'h30 + 4 * w), re ? 32'hFFFF_FFFF : 32'h0);
            wr(8'(8'h3C + 4 * w), fe ? 32'hFFFF_FFFF : 32'h0);
        end
    endtask

    // drive pin p to lvl and check the status word before and after the third edge
    task automatic edge_probe(input int p, input logic lvl, input logic hit);
        logic [31:0] d;
        logic [7:0]  sa;
        logic [31:0] exp;
        sa  = 8'(8'h48 + 4 * (p / 32));
        exp = hit ? (32'h1 << (p % 32)) : 32'h0;
        pin_in[p] = lvl;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rd(sa, d);
        check("R1 latency (not yet set)", d, 32'h0);
        @(posedge clk);
        @(negedge clk);
        rd(sa, d);
        check("R2 direction qualification", d, exp);
        check_irqs("R6/R7 request lines", hit && p == 0, hit && p == 1, hit && p >= 2);
        wr(sa, 32'hFFFF_FFFF);
        rd(sa, d);
        check("R4 clear by writing ones", d, 32'h0);
        check_irqs("R6/R7 requests drop after clear", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R5: reset state held low
        for (int w = 0; w < 9; w++) begin
            rd(8'(8'h30 + 4 * w), d);
            check("R5 reset state", d, 32'h0);
        end
        check_irqs("R5 reset requests", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R1 / R6 / R7 sweep: every pin under every enable combination
        for (int m = 0; m < 4; m++) begin
            set_modes(m[0], m[1]);
            for (int p = 0; p < NP; p++) begin
                edge_probe(p, 1'b1, m[0]);
                edge_probe(p, 1'b0, m[1]);
            end
        end

        // R3: sticky after the pin returns
        set_modes(1'b1, 1'b0);
        pin_in[5] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        pin_in[5] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(8'h48, d);
        check("R3 sticky after pin returns", d, 32'h20);
        check_irqs("R7 shared held", 1'b0, 1'b0, 1'b1);

        // R8: edge and clear in the same cycle
        pin_in[5] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr(8'h48, 32'h20);
        rd(8'h48, d);
        check("R8 edge wins over clear", d, 32'h20);
        wr(8'h48, 32'h20);
        rd(8'h48, d);
        check("R4 clear without edge", d, 32'h0);

        // R4: zeros keep bits, other words untouched
        pin_in[6]  = 1'b1;
        pin_in[40] = 1'b1;
        pin_in[0]  = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr(8'h48, 32'h0);
        rd(8'h48, d);
        check("R4 writing zero keeps bits", d, 32'h41);
        wr(8'h48, 32'h40);
        rd(8'h48, d);
        check("R4 partial clear", d, 32'h1);
        rd(8'h4C, d);
        check("R4 other word untouched", d, 32'h100);
        check_irqs("R6 pin0 request alone", 1'b1, 1'b0, 1'b1);
        wr(8'h4C, 32'h100);
        check_irqs("R7 shared drops", 1'b1, 1'b0, 1'b0);
        wr(8'h48, 32'h1);
        check_irqs("R6 pin0 drops", 1'b0, 1'b0, 1'b0);

        // R9: read/write enables and pad bits
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, d);
        check("R9 pad bits of third rise word", d, 32'h001F_FFFF);
        wr(8'h40, 32'hA5A5_A5A5);
        rd(8'h40, d);
        check("R9 fall word readback", d, 32'hA5A5_A5A5);
        rd(8'h50, d);
        check("R9 third status word", d, 32'h0);

        // R10: unmapped and unaligned addresses
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d);
        check("R10 unmapped read", d, 32'h0);
        wr(8'h31, 32'h0);
        rd(8'h31, d);
        check("R10 unaligned read", d, 32'h0);
        rd(8'h30, d);
        check("R10 unaligned write ignored", d, 32'hFFFF_FFFF);
        rd(8'h54, d);
        check("R10 past status block", d, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule